// File: doc/BRIEF.md
# Converter Lane Link-Start Sequencer

This block drives the octet stream of a single transmit lane in a serial data-converter link. Each clock it presents one octet and a flag that marks the octet as a control character. The encoder and serializer that follow it are outside the block. The receiver controls link start-up through an active-low request line. While the request is held low, the lane fills with comma characters so that the far end can find symbol boundaries. Once the request is released, the lane waits for the next multiframe boundary. It then sends an alignment sequence of exactly four multiframes. After that it passes user octets through.

The multiframe is a number of octets per frame times a number of frames per multiframe, both set by parameters. A free-running position counter marks the multiframe boundaries. Every alignment multiframe opens and closes with fixed control characters. The second alignment multiframe also carries a marker character and a short block of configuration octets. A scrambler-enable output tells the next stage when to scramble. It is never asserted over commas or alignment octets, and it is only asserted when scrambling is chosen by parameter.

Top module: `octet_lane_sequencer`

## Requirements
- R1: While reset is held, and in the cycle after it is released, the lane shows a comma: txOctet = 0xBC, txCtrl = 1, userPhase = 0, scramblerOn = 0. The multiframe position counter restarts at 0 with reset and then advances by one per clock, wrapping after FRAME_OCTETS*FRAME_COUNT octets.
- R2: If syncReqN is sampled low on a clock edge, the octet registered on that edge is a comma (0xBC, txCtrl = 1).
- R3: After syncReqN goes high, commas continue until the position counter is at its last value. The first alignment octet is registered on the edge where the position is 0.
- R4: In each alignment multiframe, position 0 carries 0x1C with txCtrl = 1, and the last position carries 0x7C with txCtrl = 1.
- R5: In the second alignment multiframe, position 1 carries 0x9C with txCtrl = 1. Positions 2 to 1+CFG_OCTETS carry configuration data with txCtrl = 0, where configuration index i holds: i=0 FRAME_OCTETS-1, i=1 FRAME_COUNT-1, i=2 the SCRAMBLE value (0 or 1), and i=3 or more holds i. Every other alignment position that is not a marker carries its own position number as data, with txCtrl = 0.
- R6: The alignment phase lasts exactly four multiframes. On the edge after the fourth closing 0x7C, user data starts: txOctet equals the userOctet sampled on that edge, txCtrl = 0, and userPhase = 1.
- R7: scramblerOn is 1 exactly when userPhase is 1 and SCRAMBLE is 1. It is 0 during commas and during alignment.
- R8: If syncReqN goes low during alignment or during user data, the next octet is a comma. After a new release, alignment starts again from the first multiframe at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncReqN | input | 1 | Active-low synchronization request from the receiver |
| userOctet | input | 8 | User data octet, sampled in the data phase |
| txOctet | output | 8 | Registered lane octet |
| txCtrl | output | 1 | txOctet is a control character |
| userPhase | output | 1 | txOctet carries user data |
| scramblerOn | output | 1 | Enable for the downstream scrambler |

## Verification
The bench builds two instances that share the same inputs. The first uses two octets per frame, four frames per multiframe, four configuration octets and scrambling on. This gives filler positions between the configuration block and the closing marker. The second uses one octet per frame, five frames, two configuration octets and scrambling off. Here the configuration block runs right up to the closing marker, and the scrambler enable must stay low. Because the multiframe lengths differ (eight and five octets), each release of the request lands at a different boundary offset in the two instances. Random request pulses then cut into both the alignment phase and the data phase at many positions.

// File: rtl/lts_pkg.sv
package lts_pkg;

  localparam logic [7:0] CH_COMMA  = 8'hBC;
  localparam logic [7:0] CH_MFOPEN = 8'h1C;
  localparam logic [7:0] CH_MFEND  = 8'h7C;
  localparam logic [7:0] CH_CFGMK  = 8'h9C;

  typedef enum logic [1:0] {
    PH_COMMA = 2'd0,
    PH_ALIGN = 2'd1,
    PH_DATA  = 2'd2
  } phase_t;

  typedef struct packed {
    logic       comma;
    logic       open;
    logic       close;
    logic       marker;
    logic       cfg;
    logic       fill;
    logic       user;
    logic [7:0] pos;
  } strobe_t;

endpackage

// File: rtl/lts_ctrl.sv
module lts_ctrl
  import lts_pkg::*;
#(
  parameter int FRAME_OCTETS = 2,
  parameter int FRAME_COUNT  = 4,
  parameter int CFG_OCTETS   = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    syncReqN,
  output strobe_t ctl
);

  localparam int MF_LEN = FRAME_OCTETS * FRAME_COUNT;
  localparam int PW     = (MF_LEN > 1) ? $clog2(MF_LEN) : 1;
  localparam logic [PW-1:0] POS_LAST   = PW'(MF_LEN - 1);
  localparam logic [PW-1:0] POS_CFGEND = PW'(CFG_OCTETS + 2);

  phase_t        state;
  logic [PW-1:0] mfPos;
  logic [1:0]    alignMf;
  logic          atLast;
  logic          atFirst;

  assign atLast  = (mfPos == POS_LAST);
  assign atFirst = (mfPos == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= PH_COMMA;
      mfPos   <= '0;
      alignMf <= '0;
    end else begin
      mfPos <= atLast ? '0 : mfPos + 1'b1;
      unique case (state)
        PH_COMMA: begin
          if (syncReqN && atLast) begin
            state   <= PH_ALIGN;
            alignMf <= '0;
          end
        end
        PH_ALIGN: begin
          if (!syncReqN) begin
            state <= PH_COMMA;
          end else if (atLast) begin
            if (alignMf == 2'd3) state <= PH_DATA;
            else                 alignMf <= alignMf + 2'd1;
          end
        end
        PH_DATA: begin
          if (!syncReqN) state <= PH_COMMA;
        end
        default: state <= PH_COMMA;
      endcase
    end
  end

  always_comb begin
    ctl     = '0;
    ctl.pos = 8'(mfPos);
    if (!syncReqN || state == PH_COMMA) begin
      ctl.comma = 1'b1;
    end else if (state == PH_DATA) begin
      ctl.user = 1'b1;
    end else if (atFirst) begin
      ctl.open = 1'b1;
    end else if (atLast) begin
      ctl.close = 1'b1;
    end else if (alignMf == 2'd1 && mfPos == PW'(1)) begin
      ctl.marker = 1'b1;
    end else if (alignMf == 2'd1 && mfPos >= PW'(2) && mfPos < POS_CFGEND) begin
      ctl.cfg = 1'b1;
    end else begin
      ctl.fill = 1'b1;
    end
  end

  // R3: alignment is entered only at a multiframe boundary
  a_r3_align_on_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == PH_ALIGN) |-> atFirst);

  // R2: exactly one octet kind is chosen per clock
  a_r2_one_kind: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ctl.comma, ctl.open, ctl.close, ctl.marker, ctl.cfg, ctl.fill, ctl.user}) == 1);

  // R6: data phase is reached only straight from alignment
  a_r6_data_from_align: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == PH_DATA) |-> ($past(state) == PH_ALIGN && $past(alignMf) == 2'd3));

endmodule

// File: rtl/lts_datapath.sv
module lts_datapath
  import lts_pkg::*;
#(
  parameter int FRAME_OCTETS = 2,
  parameter int FRAME_COUNT  = 4,
  parameter int SCRAMBLE     = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    ctl,
  input  logic [7:0] userOctet,
  output logic [7:0] txOctet,
  output logic       txCtrl,
  output logic       userPhase,
  output logic       scramblerOn
);

  function automatic logic [7:0] cfgByte(input logic [7:0] idx);
    case (idx)
      8'd0:    return 8'(FRAME_OCTETS - 1);
      8'd1:    return 8'(FRAME_COUNT - 1);
      8'd2:    return (SCRAMBLE != 0) ? 8'd1 : 8'd0;
      default: return idx;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txOctet   <= CH_COMMA;
      txCtrl    <= 1'b1;
      userPhase <= 1'b0;
    end else begin
      userPhase <= ctl.user;
      if (ctl.comma) begin
        txOctet <= CH_COMMA;
        txCtrl  <= 1'b1;
      end else if (ctl.open) begin
        txOctet <= CH_MFOPEN;
        txCtrl  <= 1'b1;
      end else if (ctl.close) begin
        txOctet <= CH_MFEND;
        txCtrl  <= 1'b1;
      end else if (ctl.marker) begin
        txOctet <= CH_CFGMK;
        txCtrl  <= 1'b1;
      end else if (ctl.cfg) begin
        txOctet <= cfgByte(ctl.pos - 8'd2);
        txCtrl  <= 1'b0;
      end else if (ctl.user) begin
        txOctet <= userOctet;
        txCtrl  <= 1'b0;
      end else begin
        txOctet <= ctl.pos;
        txCtrl  <= 1'b0;
      end
    end
  end

  generate
    if (SCRAMBLE != 0) begin : g_scr
      always_ff @(posedge clk) begin
        if (!rstN) scramblerOn <= 1'b0;
        else       scramblerOn <= ctl.user;
      end
    end else begin : g_noscr
      assign scramblerOn = 1'b0;
    end
  endgenerate

  // R7: scrambling never covers non-user octets
  a_r7_scr_only_user: assert property (@(posedge clk) disable iff (!rstN)
    scramblerOn |-> userPhase);

  // R6: user data always follows a closing multiframe character
  a_r6_user_after_close: assert property (@(posedge clk) disable iff (!rstN)
    $rose(userPhase) |-> ($past(txOctet) == CH_MFEND && $past(txCtrl)));

endmodule

// File: rtl/octet_lane_sequencer.sv
module octet_lane_sequencer
  import lts_pkg::*;
#(
  parameter int FRAME_OCTETS = 2,
  parameter int FRAME_COUNT  = 4,
  parameter int CFG_OCTETS   = 4,
  parameter int SCRAMBLE     = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncReqN,
  input  logic [7:0] userOctet,
  output logic [7:0] txOctet,
  output logic       txCtrl,
  output logic       userPhase,
  output logic       scramblerOn
);

  strobe_t ctl;

  lts_ctrl #(
    .FRAME_OCTETS(FRAME_OCTETS),
    .FRAME_COUNT (FRAME_COUNT),
    .CFG_OCTETS  (CFG_OCTETS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .syncReqN(syncReqN),
    .ctl     (ctl)
  );

  lts_datapath #(
    .FRAME_OCTETS(FRAME_OCTETS),
    .FRAME_COUNT (FRAME_COUNT),
    .SCRAMBLE    (SCRAMBLE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .userOctet  (userOctet),
    .txOctet    (txOctet),
    .txCtrl     (txCtrl),
    .userPhase  (userPhase),
    .scramblerOn(scramblerOn)
  );

  // R2, R8: a request seen on an edge forces a comma out of that edge
  a_r2_comma_on_request: assert property (@(posedge clk) disable iff (!rstN)
    !syncReqN |=> (txCtrl && txOctet == CH_COMMA && !userPhase));

endmodule

// File: tb/test_octet_lane_sequencer.sv
module test_octet_lane_sequencer;

  logic       clk = 1'b0;
  logic       rstN;
  logic       syncReqN;
  logic [7:0] userOctet;
  logic [7:0] oct0, oct1;
  logic       ctl0, ctl1, up0, up1, scr0, scr1;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  octet_lane_sequencer #(.FRAME_OCTETS(2), .FRAME_COUNT(4), .CFG_OCTETS(4), .SCRAMBLE(1))
  i_octet_lane_sequencer (
    .clk(clk), .rstN(rstN), .syncReqN(syncReqN), .userOctet(userOctet),
    .txOctet(oct0), .txCtrl(ctl0), .userPhase(up0), .scramblerOn(scr0));

  octet_lane_sequencer #(.FRAME_OCTETS(1), .FRAME_COUNT(5), .CFG_OCTETS(2), .SCRAMBLE(0))
  i_octet_lane_sequencer_alt (
    .clk(clk), .rstN(rstN), .syncReqN(syncReqN), .userOctet(userOctet),
    .txOctet(oct1), .txCtrl(ctl1), .userPhase(up1), .scramblerOn(scr1));

  // bench model state: 0 comma, 1 align, 2 data
  int         mPhase [2];
  int         mMf    [2];
  int         mPos   [2];
  logic [7:0] eOct   [2];
  logic       eCtl   [2];
  logic       eUp    [2];
  logic       eScr   [2];
  string      eReq   [2];

  function automatic int fOf(int i);   return (i == 0) ? 2 : 1; endfunction
  function automatic int kOf(int i);   return (i == 0) ? 4 : 5; endfunction
  function automatic int cfgOf(int i); return (i == 0) ? 4 : 2; endfunction
  function automatic int scrOf(int i); return (i == 0) ? 1 : 0; endfunction
  function automatic int lenOf(int i); return fOf(i) * kOf(i); endfunction

  function automatic logic [7:0] expCfg(int i, int idx);
    if (idx == 0) return 8'(fOf(i) - 1);
    if (idx == 1) return 8'(kOf(i) - 1);
    if (idx == 2) return 8'(scrOf(i));
    return 8'(idx);
  endfunction

  task automatic predict(int i);
    int L;
    L = lenOf(i);
    eUp[i] = 1'b0;
    if (!syncReqN) begin
      eOct[i] = 8'hBC; eCtl[i] = 1'b1;
      eReq[i] = (mPhase[i] == 0) ? "R2" : "R8";
      mPhase[i] = 0;
    end else if (mPhase[i] == 0) begin
      eOct[i] = 8'hBC; eCtl[i] = 1'b1; eReq[i] = "R3";
      if (mPos[i] == L - 1) begin mPhase[i] = 1; mMf[i] = 0; end
    end else if (mPhase[i] == 1) begin
      if (mPos[i] == 0) begin
        eOct[i] = 8'h1C; eCtl[i] = 1'b1; eReq[i] = "R4";
      end else if (mPos[i] == L - 1) begin
        eOct[i] = 8'h7C; eCtl[i] = 1'b1; eReq[i] = "R4";
      end else if (mMf[i] == 1 && mPos[i] == 1) begin
        eOct[i] = 8'h9C; eCtl[i] = 1'b1; eReq[i] = "R5";
      end else if (mMf[i] == 1 && mPos[i] >= 2 && mPos[i] < 2 + cfgOf(i)) begin
        eOct[i] = expCfg(i, mPos[i] - 2); eCtl[i] = 1'b0; eReq[i] = "R5";
      end else begin
        eOct[i] = 8'(mPos[i]); eCtl[i] = 1'b0; eReq[i] = "R5";
      end
      if (mPos[i] == L - 1) begin
        if (mMf[i] == 3) mPhase[i] = 2;
        else             mMf[i]++;
      end
    end else begin
      eOct[i] = userOctet; eCtl[i] = 1'b0; eUp[i] = 1'b1; eReq[i] = "R6";
    end
    eScr[i] = eUp[i] && (scrOf(i) != 0);
    mPos[i] = (mPos[i] + 1) % L;
  endtask

  task automatic checkOne(int i);
    logic [7:0] o; logic c, u, s;
    o = (i == 0) ? oct0 : oct1;
    c = (i == 0) ? ctl0 : ctl1;
    u = (i == 0) ? up0  : up1;
    s = (i == 0) ? scr0 : scr1;
    checks++;
    if (o !== eOct[i] || c !== eCtl[i] || u !== eUp[i]) begin
      errors++;
      $display("FAIL %s inst%0d: octet=%02h ctrl=%0b user=%0b expected octet=%02h ctrl=%0b user=%0b",
               eReq[i], i, o, c, u, eOct[i], eCtl[i], eUp[i]);
    end
    checks++;
    if (s !== eScr[i]) begin
      errors++;
      $display("FAIL R7 inst%0d: scramblerOn=%0b expected %0b", i, s, eScr[i]);
    end
  endtask

  task automatic cycle(input logic s, input logic [7:0] u);
    syncReqN  = s;
    userOctet = u;
    predict(0);
    predict(1);
    @(negedge clk);
    checkOne(0);
    checkOne(1);
  endtask

  task automatic runHigh(int n);
    for (int k = 0; k < n; k++) cycle(1'b1, 8'($urandom));
  endtask

  task automatic runLow(int n);
    for (int k = 0; k < n; k++) cycle(1'b0, 8'($urandom));
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; syncReqN = 1'b1; userOctet = 8'h00;
    for (int k = 0; k < 4; k++) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 2; i++) begin
      mPhase[i] = 0; mMf[i] = 0; mPos[i] = 0;
      eOct[i] = 8'hBC; eCtl[i] = 1'b1; eUp[i] = 1'b0; eScr[i] = 1'b0; eReq[i] = "R1";
      checkOne(i);
    end
    // R1, R3: immediate release counts boundaries from reset
    runHigh(50);
    // R2: hold request, then release and run into data
    runLow(5);
    runHigh(60);
    // R8: single-cycle request in the data phase
    runLow(1);
    runHigh(55);
    // R8: request in the middle of alignment
    runLow(2);
    runHigh(14);
    runLow(3);
    runHigh(60);
    // random bursts for R3..R8 at varied offsets
    for (int b = 0; b < 60; b++) begin
      runLow($urandom_range(1, 6));
      runHigh($urandom_range(1, 70));
    end
    runHigh(60);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule